// File: doc/BRIEF.md
# Hilbert Complex Sequence Correlator

This block takes 10-bit two's-complement samples that arrive one bit at a time on a data line, with a separate shift clock and a frame sync pulse. It builds an analytic signal from each sample. The imaginary part comes from a 129-tap Hilbert-transform FIR filter. The real part is the raw sample, delayed so that it lines up with the filter's centre tap. The block then correlates the complex stream against a stored sequence of ±1 chips and reports a real sum and an imaginary sum once per sample.

All arithmetic is time-multiplexed. One multiplier steps through the filter taps, and one add/subtract pass steps through the chip sequence, so each sample takes a fixed run of system clocks. Filter coefficients and chips are written through two small write ports before samples are streamed. Magnitude and peak search are done by the consumer of the two sums.

Top module: `hilbert_correlator`

## Requirements
- R1: Serial data is shifted in MSB first. A shift-clock rising edge at which the frame sync is high carries the sample's MSB. The tenth rising edge, counting that one, carries the LSB and completes the sample.
- R2: Shift-clock edges after the tenth are ignored until the frame sync is seen again. A frame sync in the middle of a word discards the partial word and starts a new one.
- R3: The imaginary part is the sum over taps i = 0..128 of coef[i] times x[n-i]. That sum is arithmetically shifted right by 15 and saturated to the 16-bit signed range. Coefficients are 16-bit signed values written through the coefficient port and take effect for later samples.
- R4: The real part is the input sample delayed by 64 samples.
- R5: Each output is the sum over k < chip_len of s[k]·z[n-k], where z[n-k] is the complex value k samples back. s[k] is +1 when chip bit k is 1 and -1 when it is 0. Histories start at zero after reset.
- R6: A chip_len of 0 gives zero sums. Any chip_len of 128 or more uses all 128 chips.
- R7: Each running sum saturates to the signed range of the output width at every step instead of wrapping.
- R8: corr_valid is a single-cycle pulse for each completed sample, and corr_re/corr_im hold their values between pulses.
- R9: After reset, corr_valid is low and both sums read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| sclk | input | 1 | Serial shift clock, sampled in the clk domain |
| sdata | input | 1 | Serial sample bit |
| fsync | input | 1 | Frame sync marking the MSB edge |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | 8 | Coefficient tap index |
| coef_wdata | input | 16 | Signed coefficient value |
| chip_we | input | 1 | Chip write strobe |
| chip_addr | input | 7 | Chip index |
| chip_wdata | input | 1 | Chip value (1 = +1, 0 = -1) |
| chip_len | input | 8 | Number of chips used |
| corr_re | output | 32 | Real correlation sum |
| corr_im | output | 32 | Imaginary correlation sum |
| corr_valid | output | 1 | One-cycle result strobe |

## Verification
The bench runs more than 64 samples so that the delayed real path reaches the sums. A delay that is off by one tap would then report the wrong earlier sample when only one chip is active. It drives the filter into clipping in both directions. A design that wraps the shifted filter output would report a sign-flipped imaginary part. A second instance with a 20-bit output width shows whether the running sums clip or overflow. Extra shift edges after a word, and a frame sync that cuts a word short, catch a converter that keeps shifting or that fails to restart. Chip lengths of 0 and 200 expose a bound check that is inverted or that indexes past the chip table.

// File: rtl/hilbert_correlator.sv
module hilbert_correlator #(
  parameter int SAMPLE_W  = 10,
  parameter int COEF_W    = 16,
  parameter int NTAPS     = 129,
  parameter int DELAY     = 64,
  parameter int COEF_FRAC = 15,
  parameter int IM_W      = 16,
  parameter int MAX_CHIPS = 128,
  parameter int OUT_W     = 32,
  localparam int CA_W     = $clog2(NTAPS),
  localparam int CH_AW    = $clog2(MAX_CHIPS),
  localparam int LEN_W    = $clog2(MAX_CHIPS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              sdata,
  input  logic              fsync,
  input  logic              coef_we,
  input  logic [CA_W-1:0]   coef_addr,
  input  logic [COEF_W-1:0] coef_wdata,
  input  logic              chip_we,
  input  logic [CH_AW-1:0]  chip_addr,
  input  logic              chip_wdata,
  input  logic [LEN_W-1:0]  chip_len,
  output logic [OUT_W-1:0]  corr_re,
  output logic [OUT_W-1:0]  corr_im,
  output logic              corr_valid
);
  localparam int BW    = $clog2(SAMPLE_W + 1);
  localparam int ACC_W = SAMPLE_W + COEF_W + $clog2(NTAPS);
  localparam int KMAX  = (NTAPS > MAX_CHIPS) ? NTAPS : MAX_CHIPS;
  localparam int KW    = $clog2(KMAX);

  typedef enum logic [2:0] {S_IDLE, S_FIR, S_PUSH, S_CORR, S_DONE} st_t;

  logic [2:0] s_clk, s_dat, s_fs;
  logic       sclk_rise, dat_s, fs_s, shift_ok;
  logic [BW-1:0] bcnt, nb;
  logic [SAMPLE_W-1:0] sh, word;
  logic pend;

  logic signed [COEF_W-1:0]   coef [NTAPS];
  logic [MAX_CHIPS-1:0]       chips;
  logic signed [SAMPLE_W-1:0] xh  [NTAPS];
  logic signed [IM_W-1:0]     wre [MAX_CHIPS];
  logic signed [IM_W-1:0]     wim [MAX_CHIPS];

  st_t st;
  logic [KW-1:0] k;
  logic [CH_AW-1:0] kc;
  logic signed [ACC_W-1:0] acc, fir_sh;
  logic signed [SAMPLE_W+COEF_W-1:0] prod;
  logic signed [IM_W-1:0] im_new;
  logic [ACC_W-IM_W:0] fir_top;
  logic signed [OUT_W-1:0] sre, sim;

  assign sclk_rise = s_clk[1] & ~s_clk[2];
  assign dat_s     = s_dat[1];
  assign fs_s      = s_fs[1];
  assign nb        = fs_s ? BW'(1) : bcnt + BW'(1);
  assign shift_ok  = sclk_rise && (fs_s || (bcnt != '0 && bcnt < BW'(SAMPLE_W)));

  assign kc      = k[CH_AW-1:0];
  assign prod    = coef[k] * xh[k];
  assign fir_sh  = acc >>> COEF_FRAC;
  assign fir_top = fir_sh[ACC_W-1:IM_W-1];
  assign im_new  = (&fir_top || ~|fir_top) ? fir_sh[IM_W-1:0]
                 : (fir_sh[ACC_W-1] ? {1'b1, {(IM_W-1){1'b0}}} : {1'b0, {(IM_W-1){1'b1}}});

  function automatic logic signed [OUT_W-1:0] sat_add(input logic signed [OUT_W-1:0] a,
                                                      input logic signed [IM_W-1:0] b,
                                                      input logic neg);
    logic signed [OUT_W:0] s;
    s = neg ? ((OUT_W+1)'(a) - (OUT_W+1)'(b)) : ((OUT_W+1)'(a) + (OUT_W+1)'(b));
    if (s[OUT_W] != s[OUT_W-1])
      return s[OUT_W] ? {1'b1, {(OUT_W-1){1'b0}}} : {1'b0, {(OUT_W-1){1'b1}}};
    return s[OUT_W-1:0];
  endfunction

  always_ff @(posedge clk)
    if (coef_we && {1'b0, coef_addr} < (CA_W+1)'(NTAPS)) coef[coef_addr] <= coef_wdata;

  always_ff @(posedge clk)
    if (chip_we) chips[chip_addr] <= chip_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_clk <= '0; s_dat <= '0; s_fs <= '0;
      bcnt <= '0; sh <= '0; word <= '0; pend <= 1'b0;
      st <= S_IDLE; k <= '0; acc <= '0; sre <= '0; sim <= '0;
      corr_re <= '0; corr_im <= '0; corr_valid <= 1'b0;
      for (int i = 0; i < NTAPS; i++) xh[i] <= '0;
      for (int i = 0; i < MAX_CHIPS; i++) begin wre[i] <= '0; wim[i] <= '0; end
    end else begin
      s_clk <= {s_clk[1:0], sclk};
      s_dat <= {s_dat[1:0], sdata};
      s_fs  <= {s_fs[1:0], fsync};
      corr_valid <= 1'b0;

      if (shift_ok) begin
        sh   <= {sh[SAMPLE_W-2:0], dat_s};
        bcnt <= nb;
        if (nb == BW'(SAMPLE_W)) word <= {sh[SAMPLE_W-2:0], dat_s};
      end
      if (st == S_IDLE && pend) pend <= 1'b0;
      if (shift_ok && nb == BW'(SAMPLE_W)) pend <= 1'b1;

      case (st)
        S_IDLE: if (pend) begin
          xh[0] <= word;
          for (int i = 1; i < NTAPS; i++) xh[i] <= xh[i-1];
          k <= '0; acc <= '0; st <= S_FIR;
        end
        S_FIR: begin
          acc <= acc + ACC_W'(prod);
          if (k == KW'(NTAPS-1)) st <= S_PUSH;
          else k <= k + KW'(1);
        end
        S_PUSH: begin
          wre[0] <= IM_W'(xh[DELAY]);
          wim[0] <= im_new;
          for (int i = 1; i < MAX_CHIPS; i++) begin wre[i] <= wre[i-1]; wim[i] <= wim[i-1]; end
          sre <= '0; sim <= '0; k <= '0; st <= S_CORR;
        end
        S_CORR: begin
          if (int'(k) < int'(chip_len)) begin
            sre <= sat_add(sre, wre[kc], ~chips[kc]);
            sim <= sat_add(sim, wim[kc], ~chips[kc]);
          end
          if (k == KW'(MAX_CHIPS-1)) st <= S_DONE;
          else k <= k + KW'(1);
        end
        default: begin
          corr_re <= sre; corr_im <= sim; corr_valid <= 1'b1;
          st <= S_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/hilbert_correlator_chk.sv
module hilbert_correlator_chk #(
  parameter int SAMPLE_W = 10,
  parameter int OUT_W    = 32,
  parameter int BW       = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             corr_valid,
  input logic [OUT_W-1:0] corr_re,
  input logic [OUT_W-1:0] corr_im,
  input logic [BW-1:0]    bcnt,
  input logic             pend,
  input logic             sclk_rise
);
  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    corr_valid |=> !corr_valid);

  // R8
  hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(corr_re) || !$stable(corr_im)) |-> corr_valid);

  // R2
  bit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bcnt <= BW'(SAMPLE_W));

  // R1
  word_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(sclk_rise));
endmodule

bind hilbert_correlator hilbert_correlator_chk #(
  .SAMPLE_W(SAMPLE_W), .OUT_W(OUT_W), .BW($clog2(SAMPLE_W + 1))
) u_chk (
  .clk(clk), .rst_n(rst_n), .corr_valid(corr_valid), .corr_re(corr_re),
  .corr_im(corr_im), .bcnt(bcnt), .pend(pend), .sclk_rise(sclk_rise)
);

// File: tb/hilbert_correlator_tb.sv
module hilbert_correlator_tb;
  localparam int HALF = 12;
  localparam int NV = 20;
  localparam int VEC_S   [NV] = '{300, -512, 511, 0, -1, 1, 257, -300, 128, -129,
                                  77, -77, 511, 511, -512, 3, 200, -200, 64, -65};
  localparam int VEC_LEN [NV] = '{128, 5, 17, 0, 128, 200, 64, 1, 33, 128,
                                  2, 90, 128, 7, 0, 128, 50, 128, 255, 11};

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, sclk, sdata, fsync, coef_we, chip_we, chip_wdata;
  logic [7:0] coef_addr, chip_len;
  logic [15:0] coef_wdata;
  logic [6:0] chip_addr;
  logic [31:0] corr_re, corr_im;
  logic [19:0] n_re, n_im;
  logic corr_valid, n_valid;

  hilbert_correlator u_dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdata(sdata), .fsync(fsync),
    .coef_we(coef_we), .coef_addr(coef_addr), .coef_wdata(coef_wdata),
    .chip_we(chip_we), .chip_addr(chip_addr), .chip_wdata(chip_wdata),
    .chip_len(chip_len), .corr_re(corr_re), .corr_im(corr_im), .corr_valid(corr_valid));

  hilbert_correlator #(.OUT_W(20)) u_dut_nar (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdata(sdata), .fsync(fsync),
    .coef_we(coef_we), .coef_addr(coef_addr), .coef_wdata(coef_wdata),
    .chip_we(chip_we), .chip_addr(chip_addr), .chip_wdata(chip_wdata),
    .chip_len(chip_len), .corr_re(n_re), .corr_im(n_im), .corr_valid(n_valid));

  int errors = 0, checks = 0, vcount = 0, nsent = 0;
  int sent [512];
  longint mc [129], mh [129], mwre [128], mwim [128];
  bit mchip [128];
  longint e_re, e_im, e_nre, e_nim;

  always @(posedge clk) if (corr_valid) vcount++;

  function automatic longint clampw(longint v, int w);
    longint hi, lo;
    hi = (64'sd1 <<< (w - 1)) - 1;
    lo = -(64'sd1 <<< (w - 1));
    return (v > hi) ? hi : ((v < lo) ? lo : v);
  endfunction

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_push(int s);
    longint acc, im, r, i_, rn, in_, sg;
    for (int i = 128; i > 0; i--) mh[i] = mh[i-1];
    mh[0] = s;
    acc = 0;
    for (int i = 0; i < 129; i++) acc += mc[i] * mh[i];
    im = clampw(acc >>> 15, 16);
    for (int i = 127; i > 0; i--) begin mwre[i] = mwre[i-1]; mwim[i] = mwim[i-1]; end
    mwre[0] = mh[64];
    mwim[0] = im;
    r = 0; i_ = 0; rn = 0; in_ = 0;
    for (int k = 0; k < 128; k++) begin
      if (k < int'(chip_len)) begin
        sg = mchip[k] ? 1 : -1;
        r = clampw(r + sg * mwre[k], 32);   i_ = clampw(i_ + sg * mwim[k], 32);
        rn = clampw(rn + sg * mwre[k], 20); in_ = clampw(in_ + sg * mwim[k], 20);
      end
    end
    e_re = r; e_im = i_; e_nre = rn; e_nim = in_;
    sent[nsent] = s; nsent++;
  endtask

  task automatic write_coef(int a, int v);
    coef_addr = 8'(a); coef_wdata = 16'(v); coef_we = 1'b1;
    mc[a] = longint'(v);
    @(negedge clk); coef_we = 1'b0;
  endtask

  task automatic write_chip(int a, bit v);
    chip_addr = 7'(a); chip_wdata = v; chip_we = 1'b1;
    mchip[a] = v;
    @(negedge clk); chip_we = 1'b0;
  endtask

  task automatic send_bits(int value, int nbits, bit fs);
    for (int i = 0; i < nbits; i++) begin
      sdata = ((value >> (nbits - 1 - i)) & 1) != 0;
      fsync = fs && (i == 0);
      repeat (HALF) @(negedge clk);
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    fsync = 1'b0;
  endtask

  task automatic wait_valid(string tag);
    int t;
    t = 0;
    while (!corr_valid && t < 2000) begin @(negedge clk); t++; end
    if (t >= 2000) check({tag, " timeout"}, 0, 1);
  endtask

  task automatic compare(string tag);
    check({tag, " wide re"}, longint'($signed(corr_re)), e_re);
    check({tag, " wide im"}, longint'($signed(corr_im)), e_im);
    check({tag, " narrow re"}, longint'($signed(n_re)), e_nre);
    check({tag, " narrow im"}, longint'($signed(n_im)), e_nim);
  endtask

  task automatic run_sample(int s, string tag);
    send_bits(s & 1023, 10, 1'b1);
    model_push(s);
    wait_valid(tag);
    compare(tag);
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int v0, v1, m;
    rst_n = 1'b0; sclk = 0; sdata = 0; fsync = 0; coef_we = 0; chip_we = 0;
    chip_wdata = 0; coef_addr = 0; coef_wdata = 0; chip_addr = 0; chip_len = 0;
    for (int i = 0; i < 129; i++) begin mc[i] = 0; mh[i] = 0; end
    for (int i = 0; i < 128; i++) begin mwre[i] = 0; mwim[i] = 0; mchip[i] = 0; end
    repeat (4) @(negedge clk);
    // R9 reset state
    check("R9 valid", longint'(corr_valid), 0);
    check("R9 re", longint'($signed(corr_re)), 0);
    check("R9 im", longint'($signed(corr_im)), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 129; i++) write_coef(i, 0);
    for (m = 1; m < 65; m += 2) begin
      write_coef(64 - m, 20861 / m);
      write_coef(64 + m, -(20861 / m));
    end
    for (int k = 0; k < 128; k++) write_chip(k, bit'(((k * k + 3 * k) >> 2) & 1));

    // R1 R3 R4 R5 R6 R7: table walked four times
    for (int p = 0; p < 4; p++)
      for (int v = 0; v < NV; v++) begin
        chip_len = 8'(VEC_LEN[v]);
        run_sample(VEC_S[v], "R5 table");
        if (VEC_LEN[v] == 0) begin
          check("R6 len0 re", longint'($signed(corr_re)), 0);
          check("R6 len0 im", longint'($signed(corr_im)), 0);
        end
      end

    // R8 pulse width and hold
    chip_len = 8'd128;
    send_bits(123, 10, 1'b1); model_push(123); wait_valid("R8");
    v0 = int'(corr_re);
    @(negedge clk);
    check("R8 pulse low", longint'(corr_valid), 0);
    repeat (100) @(negedge clk);
    check("R8 hold", longint'(int'(corr_re)), longint'(v0));

    // R4 delay: only chip 0 (+1) active, real sum is the sample 64 back
    write_chip(0, 1'b1);
    chip_len = 8'd1;
    run_sample(-7, "R4");
    check("R4 delay", longint'($signed(corr_re)), longint'(sent[nsent - 1 - 64]));

    // R2 extra edges ignored
    chip_len = 8'd128;
    v1 = vcount;
    send_bits(-100 & 1023, 10, 1'b1);
    send_bits(31, 5, 1'b0);
    model_push(-100);
    wait_valid("R2 extra");
    compare("R2 extra");
    repeat (600) @(negedge clk);
    check("R2 extra count", longint'(vcount - v1), 1);

    // R2 resync mid-word
    v1 = vcount;
    send_bits(5, 4, 1'b1);
    run_sample(345, "R2 resync");
    repeat (300) @(negedge clk);
    check("R2 resync count", longint'(vcount - v1), 1);

    // R3 R7 positive clipping
    for (int i = 0; i < 129; i++) write_coef(i, 32767);
    for (int k = 0; k < 128; k++) write_chip(k, 1'b1);
    chip_len = 8'd32;
    for (int i = 0; i < 70; i++) run_sample(511, "R7 pos");
    check("R7 narrow im max", longint'($signed(n_im)), 524287);
    chip_len = 8'd1;
    run_sample(511, "R3 pos");
    check("R3 imag clip max", longint'($signed(corr_im)), 32767);

    // R3 R7 negative clipping
    for (int i = 0; i < 129; i++) write_coef(i, -32768);
    chip_len = 8'd17;
    for (int i = 0; i < 20; i++) run_sample(511, "R7 neg");
    check("R7 narrow im min", longint'($signed(n_im)), -524288);
    check("R3 wide im neg", longint'($signed(corr_im)), -557056);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule